// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus side of a byte-addressed serial memory that only ever acts as a slave on a two-wire bus. It cleans the clock and data lines with a two-flop synchronizer followed by a persistence filter, finds start and stop conditions, and shifts in a control byte, a two-byte word address and data bytes. It acknowledges bytes and returns read data by pulling the data line low through an output enable, in open-drain style.

Storage lives in a separate back-end controller. Each accepted write byte becomes a one-cycle write strobe carrying address and data. Each byte to be sent out becomes a one-cycle read strobe, and the back end answers on the following cycle. While the back end raises its busy input for a self-timed programming cycle, the block acknowledges nothing. When it transmits, it changes the data line only a configurable number of system clocks after the clock line falls, so that it cannot create a false start or stop.

Top module: `twowire_mem_slave`

## Requirements
- R1: After reset `sdaOe` is 0, and `wrReq` and `rdReq` are 0.
- R2: A falling data line while the clock line is high is a start and a rising one is a stop. After a stop, bus activity is ignored (no acknowledge) until the next start. A start at any point, including a repeated start, begins a new control byte.
- R3: The control byte, sent MSB first, has bits [7:4] = 4'b1010, bits [3:1] equal to `devSel` and bit [0] = 1 for read or 0 for write. On any mismatch no acknowledge is given and the block ignores the bus until the next start.
- R4: The block acknowledges each accepted byte by holding the data line low through the high phase of the ninth clock.
- R5: After a write control byte, the next two bytes set the word address, high byte first. Bits [7:5] of the high byte are ignored, which gives a 13-bit address.
- R6: Each accepted data byte gives exactly one one-cycle `wrReq` carrying the current address and the byte. The address then increments and wraps from 8191 to 0.
- R7: While `memBusy` is 1 when a byte completes, that byte is not acknowledged, no `wrReq` is issued, and the block ignores the bus until the next start.
- R8: A read control byte returns data MSB first from the current address. A write control byte plus two address bytes, followed by a repeated start and a read control byte, reads from that address. Each byte needs one one-cycle `rdReq` with `rdAddr`, and `rdData` is sampled on the next cycle. The address increments after every byte sent and wraps from 8191 to 0.
- R9: A missing master acknowledge after a read byte ends the transfer, and the data line stays released.
- R10: `sdaOe` changes only while the clock line is low, and never sooner than HOLD_CYC system clocks after the clock line falls.
- R11: Pulses on the clock or data line shorter than FILT_LEN system clocks have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaOe | output | 1 | 1 pulls the data line low |
| devSel | input | 3 | Device select strap value |
| memBusy | input | 1 | Back end is in a programming cycle |
| wrReq | output | 1 | One-cycle byte write strobe |
| wrAddr | output | 13 | Write address |
| wrData | output | 8 | Write data |
| rdReq | output | 1 | One-cycle byte read strobe |
| rdAddr | output | 13 | Read address |
| rdData | input | 8 | Read data, valid the cycle after `rdReq` |

## Verification
The bench builds the block with FILT_LEN = 4 and HOLD_CYC = 32, and drives the bus with a clock half period of 60 system clocks. With these values, 3-clock glitches on either line fall just under the rejection threshold. The hold delay plus the synchronizer and filter latency also stays well inside the clock low phase, so a shortened hold shows up as a data-line change too close to the falling edge. A 13-bit address lets the bench write and read across the wrap from 8191 to 0 without long sequences.

// File: rtl/twm_pkg.sv
package twm_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [1:0] {DRV_KEEP, DRV_REL, DRV_ACK, DRV_TX} drvSel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT
  } state_e;

  typedef struct packed {
    logic     shiftIn;
    logic     shiftTx;
    logic     loadTx;
    logic     loadHi;
    logic     loadLo;
    logic     incAddr;
    logic     wrReq;
    logic     rdReq;
    logic     relNow;
    drvSel_e  drv;
  } strobe_t;
endpackage

// File: rtl/twm_datapath.sv
module twm_datapath
  import twm_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int HOLD_CYC = 32,
  parameter int ADDR_W   = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  strobe_t           strb,
  input  logic [7:0]        rdData,
  output logic              evStart,
  output logic              evStop,
  output logic              evRise,
  output logic              evFall,
  output logic              sdaF,
  output logic [7:0]        rxByte,
  output logic              sdaOe,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr
);
  localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam int HC_W  = $clog2(HOLD_CYC + 1);

  logic [1:0] sclSync, sdaSync, rawS, filt;
  logic sclF, sclD, sdaD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
    end
  end

  assign rawS = {sclSync[1], sdaSync[1]};

  // persistence filter: a new level must be seen FILT_LEN clocks in a row
  for (genvar g = 0; g < 2; g++) begin : g_filt
    logic [CNT_W-1:0] cnt;
    logic fq;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt <= '0;
        fq  <= 1'b1;
      end else if (rawS[g] == fq) begin
        cnt <= '0;
      end else if (cnt == CNT_W'(FILT_LEN - 1)) begin
        fq  <= rawS[g];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
    assign filt[g] = fq;
  end

  assign sclF = filt[1];
  assign sdaF = filt[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclF;
      sdaD <= sdaF;
    end
  end

  assign evRise  = sclF & ~sclD;
  assign evFall  = ~sclF & sclD;
  assign evStart = sclF & sclD & sdaD & ~sdaF;
  assign evStop  = sclF & sclD & ~sdaD & sdaF;

  // shift register, address counter, read buffer
  logic [7:0] shReg, rdBuf;
  logic [ADDR_W-1:0] addrQ, addrNext;
  logic rdPend;

  always_comb begin
    addrNext = addrQ;
    if (strb.loadHi) addrNext[ADDR_W-1:8] = shReg[ADDR_W-9:0];
    if (strb.loadLo) addrNext[7:0] = shReg;
    if (strb.incAddr) addrNext = addrQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      rdBuf  <= '0;
      addrQ  <= '0;
      rdPend <= 1'b0;
      wrReq  <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
      rdReq  <= 1'b0;
      rdAddr <= '0;
    end else begin
      if (strb.shiftIn)      shReg <= {shReg[6:0], sdaF};
      else if (strb.loadTx)  shReg <= rdBuf;
      else if (strb.shiftTx) shReg <= {shReg[6:0], 1'b1};
      addrQ  <= addrNext;
      wrReq  <= strb.wrReq;
      rdReq  <= strb.rdReq;
      rdPend <= rdReq;
      if (strb.wrReq) begin
        wrAddr <= addrQ;
        wrData <= shReg;
      end
      if (strb.rdReq) rdAddr <= addrNext;
      if (rdPend) rdBuf <= rdData;
    end
  end

  assign rxByte = shReg;

  // delayed open-drain drive
  logic oePend, oeVal;
  logic [HC_W-1:0] holdCnt;

  always_comb begin
    case (strb.drv)
      DRV_ACK: oeVal = 1'b1;
      DRV_TX:  oeVal = strb.loadTx ? ~rdBuf[7] : ~shReg[6];
      default: oeVal = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaOe   <= 1'b0;
      oePend  <= 1'b0;
      holdCnt <= '0;
    end else if (strb.relNow) begin
      sdaOe   <= 1'b0;
      holdCnt <= '0;
    end else if (strb.drv != DRV_KEEP) begin
      oePend  <= oeVal;
      holdCnt <= HC_W'(HOLD_CYC);
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
      if (holdCnt == HC_W'(1)) sdaOe <= oePend;
    end
  end
endmodule

// File: rtl/twm_control.sv
module twm_control
  import twm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evStart,
  input  logic       evStop,
  input  logic       evRise,
  input  logic       evFall,
  input  logic       sdaF,
  input  logic [7:0] rxByte,
  input  logic [2:0] devSel,
  input  logic       memBusy,
  output strobe_t    strb
);
  state_e stateQ, stateD;
  logic [3:0] bitQ, bitD;
  logic readQ, readD, mAckQ, mAckD;
  logic rxMode, ctrlOk, byteOk;

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    bitD   = bitQ;
    readD  = readQ;
    mAckD  = mAckQ;
    rxMode = stateQ inside {ST_CTRL, ST_AHI, ST_ALO, ST_WDAT};
    ctrlOk = (rxByte[7:4] == DEV_CODE) && (rxByte[3:1] == devSel);
    byteOk = !memBusy && (stateQ != ST_CTRL || ctrlOk);
    if (evStart) begin
      stateD = ST_CTRL;
      bitD = '0;
      strb.relNow = 1'b1;
    end else if (evStop) begin
      stateD = ST_IDLE;
      bitD = '0;
      strb.relNow = 1'b1;
    end else if (stateQ != ST_IDLE) begin
      if (evRise) begin
        if (bitQ < 4'd8) begin
          bitD = bitQ + 4'd1;
          strb.shiftIn = rxMode;
        end else if (bitQ == 4'd9 && stateQ == ST_RDAT) begin
          mAckD = !sdaF;
        end
      end else if (evFall) begin
        if (bitQ == 4'd8) begin
          bitD = 4'd9;
          if (rxMode) begin
            if (byteOk) begin
              strb.drv = DRV_ACK;
              case (stateQ)
                ST_CTRL: begin readD = rxByte[0]; strb.rdReq = rxByte[0]; end
                ST_AHI:  strb.loadHi = 1'b1;
                ST_ALO:  strb.loadLo = 1'b1;
                default: begin strb.wrReq = 1'b1; strb.incAddr = 1'b1; end
              endcase
            end else begin
              stateD = ST_IDLE;
              bitD = '0;
            end
          end else begin
            strb.drv = DRV_REL;
            strb.incAddr = 1'b1;
            strb.rdReq = 1'b1;
          end
        end else if (bitQ == 4'd9) begin
          bitD = '0;
          case (stateQ)
            ST_CTRL: begin
              if (readQ) begin
                stateD = ST_RDAT;
                strb.loadTx = 1'b1;
                strb.drv = DRV_TX;
              end else begin
                stateD = ST_AHI;
                strb.drv = DRV_REL;
              end
            end
            ST_AHI:  begin stateD = ST_ALO;  strb.drv = DRV_REL; end
            ST_ALO:  begin stateD = ST_WDAT; strb.drv = DRV_REL; end
            ST_WDAT: strb.drv = DRV_REL;
            default: begin
              if (mAckQ) begin
                strb.loadTx = 1'b1;
                strb.drv = DRV_TX;
              end else begin
                stateD = ST_IDLE;
              end
            end
          endcase
        end else if (stateQ == ST_RDAT && bitQ != 4'd0) begin
          strb.shiftTx = 1'b1;
          strb.drv = DRV_TX;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      bitQ   <= '0;
      readQ  <= 1'b0;
      mAckQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      bitQ   <= bitD;
      readQ  <= readD;
      mAckQ  <= mAckD;
    end
  end
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave
  import twm_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int HOLD_CYC = 32,
  parameter int ADDR_W   = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [2:0]        devSel,
  input  logic              memBusy,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData
);
  strobe_t strb;
  logic evStart, evStop, evRise, evFall, sdaF;
  logic [7:0] rxByte;

  twm_datapath #(.FILT_LEN(FILT_LEN), .HOLD_CYC(HOLD_CYC), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .rdData(rdData), .evStart(evStart), .evStop(evStop), .evRise(evRise),
    .evFall(evFall), .sdaF(sdaF), .rxByte(rxByte), .sdaOe(sdaOe),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .rdReq(rdReq), .rdAddr(rdAddr)
  );

  twm_control ctl_i (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop), .evRise(evRise),
    .evFall(evFall), .sdaF(sdaF), .rxByte(rxByte), .devSel(devSel),
    .memBusy(memBusy), .strb(strb)
  );
endmodule

// File: rtl/twowire_mem_slave_chk.sv
module twowire_mem_slave_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaOe,
  input logic memBusy,
  input logic wrReq,
  input logic rdReq
);
  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) || $fell(sdaOe)) |-> !sclIn);  // R10
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> !wrReq);  // R6
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);  // R8
  AST_NO_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> !$past(memBusy));  // R7
  AST_RD_WR_APART: assert property (@(posedge clk) disable iff (!rstN)
    !(wrReq && rdReq));  // R8
endmodule

bind twowire_mem_slave twowire_mem_slave_chk chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .memBusy(memBusy), .wrReq(wrReq), .rdReq(rdReq)
);

// File: tb/twowire_mem_slave_tb_top.sv
`timescale 1ns/1ps
module twowire_mem_slave_tb_top;
  localparam int FILT_LEN = 4;
  localparam int HOLD_CYC = 32;
  localparam int T = 60;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] CW = {4'b1010, SEL, 1'b0};
  localparam logic [7:0] CR = {4'b1010, SEL, 1'b1};

  logic clk = 1'b0, rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1, memBusy = 1'b0;
  logic sdaOe, wrReq, rdReq, sdaLine;
  logic [12:0] wrAddr, rdAddr;
  logic [7:0] wrData, rdData = 8'h00;
  int nChk = 0, nFail = 0, sinceFall = 0;
  logic prevOe = 1'b0;
  logic [7:0] mem [int];
  logic [20:0] wrLog[$], wrExp[$];

  always #5 clk = ~clk;
  assign sdaLine = sdaDrv & ~sdaOe;

  twowire_mem_slave #(.FILT_LEN(FILT_LEN), .HOLD_CYC(HOLD_CYC), .ADDR_W(13)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .devSel(SEL), .memBusy(memBusy), .wrReq(wrReq), .wrAddr(wrAddr),
    .wrData(wrData), .rdReq(rdReq), .rdAddr(rdAddr), .rdData(rdData)
  );

  // back-end storage model
  always @(posedge clk) begin
    if (wrReq) begin
      mem[int'(wrAddr)] = wrData;
      wrLog.push_back({wrAddr, wrData});
    end
    if (rdReq) rdData <= mem.exists(int'(rdAddr)) ? mem[int'(rdAddr)] : 8'hFF;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock hold check on every data-line drive change
  always @(negedge clk) begin
    if (rstN) begin
      if (sclDrv) sinceFall = 0; else sinceFall++;
      if (sdaOe !== prevOe)
        chk(!sclDrv && sinceFall >= HOLD_CYC, "R10 drive change spacing", sinceFall, HOLD_CYC);
    end
    prevOe = sdaOe;
  end

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitClk(T);
    sclDrv = 1'b1; waitClk(T/2);
    sdaDrv = 1'b0; waitClk(T/2);
    sclDrv = 1'b0;
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitClk(T);
    sclDrv = 1'b1; waitClk(T/2);
    sdaDrv = 1'b1; waitClk(T);
  endtask

  // glitch: 0 none, 1 short clock pulse while low, 2 short data pulse while high
  task automatic clockBit(input logic b, input int glitch, output logic seen);
    sdaDrv = b;
    if (glitch == 1) begin
      waitClk(48); sclDrv = 1'b1; waitClk(FILT_LEN - 1); sclDrv = 1'b0;
      waitClk(T - 48 - (FILT_LEN - 1));
    end else waitClk(T);
    sclDrv = 1'b1;
    if (glitch == 2) begin
      waitClk(T/4); sdaDrv = ~b; waitClk(FILT_LEN - 1); sdaDrv = b;
      waitClk(T/2 - T/4 - (FILT_LEN - 1));
    end else waitClk(T/2);
    seen = sdaLine;
    waitClk(T/2);
    sclDrv = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] v, input int glitchBit, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(v[i], (i == glitchBit) ? 1 : ((i == glitchBit - 2) ? 2 : 0), s);
    clockBit(1'b1, 0, s);
    ack = !s;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, 0, s);
      v[i] = s;
    end
    clockBit(!giveAck, 0, s);
  endtask

  task automatic checkWrites(input string req);
    chk(wrLog.size() == wrExp.size(), req, wrLog.size(), wrExp.size());
    for (int i = 0; i < wrExp.size() && i < wrLog.size(); i++)
      chk(wrLog[i] == wrExp[i], req, int'(wrLog[i]), int'(wrExp[i]));
    wrLog.delete();
    wrExp.delete();
  endtask

  task automatic setAddr(input logic [7:0] hi, input logic [7:0] lo, input string req);
    logic a;
    writeByte(CW, -9, a); chk(a, {req, " R3 control ack"}, a, 1);
    writeByte(hi, -9, a); chk(a, {req, " R5 high address ack"}, a, 1);
    writeByte(lo, -9, a); chk(a, {req, " R5 low address ack"}, a, 1);
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    mem[32'h0126] = 8'h99;
    mem[32'h0001] = 8'h4E;
    waitClk(10);
    chk(sdaOe == 1'b0, "R1 sdaOe in reset", sdaOe, 0);
    chk(wrReq == 1'b0 && rdReq == 1'b0, "R1 strobes in reset", {wrReq, rdReq}, 0);
    rstN = 1'b1;
    waitClk(10);

    // write with ignored upper address bits
    busStart();
    setAddr(8'hE1, 8'h23, "wr");
    writeByte(8'hA5, -9, a); chk(a, "R4 data ack", a, 1);
    writeByte(8'h5A, -9, a); chk(a, "R4 data ack", a, 1);
    writeByte(8'h3C, -9, a); chk(a, "R4 data ack", a, 1);
    busStop();
    wrExp.push_back({13'h0123, 8'hA5});
    wrExp.push_back({13'h0124, 8'h5A});
    wrExp.push_back({13'h0125, 8'h3C});
    checkWrites("R6 R5 write sequence");

    // random read via repeated start, then master nack
    busStart();
    setAddr(8'h01, 8'h24, "rr");
    busStart();
    writeByte(CR, -9, a); chk(a, "R2 repeated start control ack", a, 1);
    readByte(1'b1, d); chk(d == 8'h5A, "R8 random read", d, 8'h5A);
    readByte(1'b1, d); chk(d == 8'h3C, "R8 sequential read", d, 8'h3C);
    readByte(1'b0, d); chk(d == 8'h99, "R8 sequential read", d, 8'h99);
    waitClk(T);
    chk(sdaOe == 1'b0, "R9 released after master nack", sdaOe, 0);
    clockBit(1'b1, 0, a); chk(a == 1'b1, "R9 line stays high", a, 1);
    busStop();

    // wrong select, wrong family code, no start
    busStart();
    writeByte({4'b1010, 3'b100, 1'b0}, -9, a); chk(!a, "R3 wrong select nack", a, 0);
    writeByte(8'h00, -9, a); chk(!a, "R3 ignored until start", a, 0);
    busStop();
    busStart();
    writeByte({4'b0010, SEL, 1'b0}, -9, a); chk(!a, "R3 wrong family nack", a, 0);
    busStop();
    writeByte(CW, -9, a); chk(!a, "R2 no ack without start", a, 0);
    busStop();
    checkWrites("R3 no writes");

    // busy back end
    memBusy = 1'b1;
    busStart();
    writeByte(CW, -9, a); chk(!a, "R7 busy control nack", a, 0);
    busStop();
    memBusy = 1'b0;
    busStart();
    setAddr(8'h00, 8'h10, "busy");
    memBusy = 1'b1;
    writeByte(8'h11, -9, a); chk(!a, "R7 busy data nack", a, 0);
    busStop();
    memBusy = 1'b0;
    checkWrites("R7 no write while busy");

    // wrap on write and read
    busStart();
    setAddr(8'hFF, 8'hFF, "wrap");
    writeByte(8'hD1, -9, a); chk(a, "R6 ack", a, 1);
    writeByte(8'hD2, -9, a); chk(a, "R6 ack after wrap", a, 1);
    busStop();
    wrExp.push_back({13'h1FFF, 8'hD1});
    wrExp.push_back({13'h0000, 8'hD2});
    checkWrites("R6 address wrap");
    busStart();
    setAddr(8'h1F, 8'hFF, "wrap rd");
    busStart();
    writeByte(CR, -9, a); chk(a, "R2 repeated start ack", a, 1);
    readByte(1'b1, d); chk(d == 8'hD1, "R8 read at top", d, 8'hD1);
    readByte(1'b0, d); chk(d == 8'hD2, "R8 read wrap", d, 8'hD2);
    busStop();

    // current-address read
    busStart();
    writeByte(CR, -9, a); chk(a, "R3 read control ack", a, 1);
    readByte(1'b0, d); chk(d == 8'h4E, "R8 current address read", d, 8'h4E);
    busStop();

    // glitches on both lines during a data byte
    busStart();
    setAddr(8'h02, 8'h00, "glitch");
    writeByte(8'h96, 5, a); chk(a, "R11 ack with glitches", a, 1);
    busStop();
    wrExp.push_back({13'h0200, 8'h96});
    checkWrites("R11 glitches ignored");

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule